// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets an external management agent read and write the device's configuration registers over a two-wire serial bus made of a clock line and a data line. It oversamples both lines with the system clock, passes each through a synchronizer, and detects START, repeated START and STOP from the synchronized samples. It answers one 7-bit slave address. Part of that address is fixed, and the rest comes from strap pins.

The strap pins are sampled throughout the reset period, and the value held at reset release is kept. After a matching address byte, the first byte of a write sets an internal register pointer, and every later byte is written to the register file through a one-cycle write strobe. A read uses a pointer write, then a repeated START and the address with the read bit set. The slave then returns register bytes, MSB first, until the master answers a byte with NACK. The pointer advances after every data byte, whether written or read.

The data line is open-drain: the block only asserts an output enable that pulls the line low. It changes that enable only while the synchronized clock line is low.

Top module: `smb_cfg_slave`

## Requirements
- R1: While `rst` is high and after it falls, before any bus traffic, `sda_oe`, `reg_wr` and `reg_rd` are all 0.
- R2: `addr_strap` is captured while `rst` is high, and the value present at reset release is held. A later change on `addr_strap` without a reset has no effect on which address is answered.
- R3: The answered 7-bit address, MSB first, is 1, 1, `addr_strap[3]`, 0, `addr_strap[2]`, `addr_strap[1]`, `addr_strap[0]`. Bit 0 of the address byte selects read (1) or write (0).
- R4: In a transaction with a matching address, the slave acknowledges the address byte, the pointer byte and every written data byte by pulling SDA low during the ninth clock.
- R5: In a write, the byte after the address sets the pointer. Each following byte produces exactly one single-cycle `reg_wr` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. `reg_wr` and `reg_rd` are never high together.
- R6: In a read, each returned byte is the `reg_rdata` of the pointer, sent MSB first. `reg_rdata` is taken in the cycle after a `reg_rd` pulse, and `reg_rd` is raised only at the address acknowledge or after a master ACK.
- R7: The pointer increases by one after each data byte in either direction, wraps from the highest pointer value to 0, and persists between transactions.
- R8: After the master answers a read byte with NACK, the slave drives nothing and issues no `reg_rd` until the next START.
- R9: When the address does not match, the slave gives no acknowledge and issues no strobes for the rest of that transaction.
- R10: A STOP releases SDA and returns the slave to idle. The next START begins a fresh transaction.
- R11: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| addr_strap | input | 4 | Address strap pins |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| reg_addr | output | PTR_W | Register address for a strobe |
| reg_wdata | output | 8 | Register write data |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Register read data, valid the cycle after `reg_rd` |

## Verification
The bench builds the block with `PTR_W = 8`, so the pointer can be set to its top value with a single byte, and the wrap from 255 to 0 is reached within one short write burst. `SYNC_STAGES = 3` is used in place of the default of two, which puts the longest edge-detection delay against a bus quarter-period of eight system clocks. This is the margin the acknowledge hand-over and the transmit bits depend on. Straps are changed both with and without a reset in between, so that address latching and address composition are each seen at the acknowledge bit.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } smb_state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } smb_kind_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic dprev
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe  <= '1;
      dprev <= 1'b1;
    end else begin
      pipe  <= {pipe[STAGES-2:0], din};
      dprev <= pipe[STAGES-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
  import smb_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        dev_addr,
  input  logic              scl_s,
  input  logic              scl_p,
  input  logic              sda_s,
  input  logic              sda_p,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  smb_state_t        state;
  smb_kind_t         kind;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txbuf;
  logic [PTR_W-1:0]  ptr;
  logic              is_read;
  logic              rd_pend;

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      txbuf     <= '0;
      ptr       <= '0;
      is_read   <= 1'b0;
      rd_pend   <= 1'b0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      rd_pend <= reg_rd;
      if (start_det) begin
        state  <= ST_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (kind)
                K_ADDR: begin
                  if (shreg[7:1] == dev_addr) begin
                    sda_oe  <= 1'b1;
                    state   <= ST_ACK;
                    is_read <= shreg[0];
                    if (shreg[0]) begin
                      reg_rd   <= 1'b1;
                      reg_addr <= ptr;
                    end else begin
                      kind <= K_PTR;
                    end
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                K_PTR: begin
                  ptr    <= PTR_W'(shreg);
                  kind   <= K_DATA;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
                default: begin
                  reg_wr    <= 1'b1;
                  reg_addr  <= ptr;
                  reg_wdata <= shreg;
                  ptr       <= ptr + 1'b1;
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (is_read) begin
                state  <= ST_TX;
                sda_oe <= ~txbuf[7];
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
                ptr    <= ptr + 1'b1;
              end else begin
                bitcnt <= bitcnt + 4'd1;
                txbuf  <= {txbuf[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txbuf[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                reg_rd   <= 1'b1;
                reg_addr <= ptr;
              end else begin
                state <= ST_SKIP;
              end
            end else if (scl_fall) begin
              state  <= ST_TX;
              bitcnt <= '0;
              sda_oe <= ~txbuf[7];
            end
          end
          default: ;
        endcase
      end
      if (rd_pend) txbuf <= reg_rdata;
    end
  end

  // R11: the data line moves only while the clock line is low
  assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R5: write and read strobes never overlap, and a write strobe lasts one cycle
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));
  assert_wr_single_R5: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  // R6: read strobes occur only around an acknowledge
  assert_rd_context_R6: assert property (@(posedge clk) disable iff (rst)
    reg_rd |-> (state == ST_ACK || state == ST_MACK));

  // R9 and R8: a skipped transaction is silent
  assert_skip_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> (!sda_oe && !reg_wr && !reg_rd));

  // R10: a STOP releases the line and returns to idle
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_oe));
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        addr_strap,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_raw, line_s, line_p;
  logic [3:0]       strap_q;
  logic [6:0]       dev_addr;

  assign line_raw = {sda_in, scl_in};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_sync
      smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (line_raw[g]),
        .dout (line_s[g]),
        .dprev(line_p[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) strap_q <= addr_strap;
  end

  assign dev_addr = {2'b11, strap_q[3], 1'b0, strap_q[2:0]};

  smb_slave_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .dev_addr (dev_addr),
    .scl_s    (line_s[0]),
    .scl_p    (line_p[0]),
    .sda_s    (line_s[1]),
    .sda_p    (line_p[1]),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: tb/smb_cfg_slave_test.sv
module smb_cfg_slave_test;
  localparam int CLK_P = 10;
  localparam int Q     = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] strap = 4'b0101;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd;
  logic       sda_line;

  int n_chk = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0, oe_bad = 0;
  logic [7:0] regs [256];
  logic       oe_prev = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  smb_cfg_slave #(.PTR_W(8), .SYNC_STAGES(3)) uut (
    .clk(clk), .rst(rst), .addr_strap(strap), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) regs[i] <= 8'(i) ^ 8'h5A;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin regs[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
      if (reg_rd) begin reg_rdata <= regs[reg_addr]; rd_cnt <= rd_cnt + 1; end
    end
    if (!rst && sda_oe != oe_prev && scl_m) oe_bad <= oe_bad + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic m_wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
    m_rbit(b);
    ack = ~b;
  endtask

  task automatic m_rbyte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_rbit(b); v[i] = b; end
    m_wbit(~give_ack);
  endtask

  task automatic do_reset(input logic [3:0] s);
    strap = s; rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    strap = ~s;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [6:0] addr_of(input logic [3:0] s);
    return {2'b11, s[3], 1'b0, s[2:0]};
  endfunction

  task automatic t_reset();
    strap = 4'b0101; rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", sda_oe, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 oe", sda_oe, 0);
    chk("R1 wr", reg_wr, 0);
    chk("R1 rd", reg_rd, 0);
  endtask

  task automatic t_write_burst();
    logic a; int acks = 0; int w0 = wr_cnt;
    m_start();
    m_wbyte({addr_of(4'b0101), 1'b0}, a); acks += int'(a);
    m_wbyte(8'h10, a); acks += int'(a);
    m_wbyte(8'hA5, a); acks += int'(a);
    m_wbyte(8'h3C, a); acks += int'(a);
    m_wbyte(8'h0F, a); acks += int'(a);
    m_stop();
    chk("R4 acks on write", acks, 5);
    chk("R5 write count", wr_cnt - w0, 3);
    chk("R5 reg 10", regs[8'h10], 8'hA5);
    chk("R7 reg 11", regs[8'h11], 8'h3C);
    chk("R7 reg 12", regs[8'h12], 8'h0F);
  endtask

  task automatic t_read_burst();
    logic a; logic [7:0] v0, v1, v2; int r0;
    m_start();
    m_wbyte({addr_of(4'b0101), 1'b0}, a);
    m_wbyte(8'h10, a);
    m_start();
    r0 = rd_cnt;
    m_wbyte({addr_of(4'b0101), 1'b1}, a);
    chk("R4 read addr ack", a, 1);
    m_rbyte(v0, 1'b1);
    m_rbyte(v1, 1'b1);
    m_rbyte(v2, 1'b0);
    chk("R6 read 10", v0, 8'hA5);
    chk("R7 read 11", v1, 8'h3C);
    chk("R7 read 12", v2, 8'h0F);
    m_rbyte(v0, 1'b0);
    chk("R8 idle after nack", v0, 8'hFF);
    chk("R8 read strobes", rd_cnt - r0, 3);
    m_stop();
  endtask

  task automatic t_wrong_addr();
    logic a; int w0 = wr_cnt; logic [7:0] keep = regs[8'h20];
    m_start();
    m_wbyte({addr_of(4'b0101) ^ 7'h01, 1'b0}, a);
    chk("R9 no ack", a, 0);
    m_wbyte(8'h20, a);
    chk("R9 no ack ptr", a, 0);
    m_wbyte(8'h77, a);
    m_stop();
    chk("R9 no write", wr_cnt - w0, 0);
    chk("R9 reg kept", regs[8'h20], keep);
    m_start();
    m_wbyte({addr_of(4'b0101) | 7'h08, 1'b0}, a);
    m_stop();
    chk("R3 fixed zero bit", a, 0);
  endtask

  task automatic t_strap_change();
    logic a;
    strap = 4'b1010;
    repeat (4) @(negedge clk);
    m_start(); m_wbyte({addr_of(4'b0101), 1'b0}, a); m_stop();
    chk("R2 old addr kept", a, 1);
    m_start(); m_wbyte({addr_of(4'b1010), 1'b0}, a); m_stop();
    chk("R2 new strap ignored", a, 0);
  endtask

  task automatic t_strap_reset();
    logic a;
    do_reset(4'b1010);
    m_start(); m_wbyte({addr_of(4'b1010), 1'b0}, a); m_stop();
    chk("R3 strap address", a, 1);
    m_start(); m_wbyte({addr_of(4'b0101), 1'b0}, a); m_stop();
    chk("R3 old address", a, 0);
  endtask

  task automatic t_wrap();
    logic a;
    m_start();
    m_wbyte({addr_of(4'b1010), 1'b0}, a);
    m_wbyte(8'hFF, a);
    m_wbyte(8'h11, a);
    m_wbyte(8'h22, a);
    m_stop();
    chk("R7 reg ff", regs[8'hFF], 8'h11);
    chk("R7 wrap to 00", regs[8'h00], 8'h22);
  endtask

  task automatic t_stop_mid();
    logic a; int w0;
    m_start();
    m_wbyte({addr_of(4'b1010), 1'b0}, a);
    m_wbit(1'b1);
    m_stop();
    chk("R10 released", sda_oe, 0);
    w0 = wr_cnt;
    m_start();
    m_wbyte({addr_of(4'b1010), 1'b0}, a);
    chk("R10 fresh ack", a, 1);
    m_wbyte(8'h40, a);
    m_wbyte(8'h99, a);
    m_stop();
    chk("R10 fresh write", regs[8'h40], 8'h99);
    chk("R10 one write", wr_cnt - w0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_write_burst();
    t_read_burst();
    t_wrong_addr();
    t_strap_change();
    t_strap_reset();
    t_wrap();
    t_stop_mid();
    chk("R11 oe moved with scl high", oe_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule